// File: doc/BRIEF.md
# Variable-Size Sub-Block Cyclic Rotator

This block performs the core operation of a quasi-cyclic parity-check encoder: it multiplies a Z-bit slice of data by a cyclically shifted identity sub-matrix. The caller picks Z for each operation from three sizes, 27, 54 or 81 bits, with a 2-bit size select. All three sizes share one datapath that is 81 bits wide. The caller also supplies a 7-bit shift value taken from a base-matrix entry. Only the low Z bits of the input take part in the rotation, and the output bits at position Z and above are always zero.

One shift value is reserved to mean a zero sub-matrix. It gives an all-zero product and is not treated as an error. A shift value that does not fit the chosen size gives an all-zero result and raises an error flag, and so does an unused size select. The result, its valid strobe and its error flag are registered, with one cycle of latency. The three sizes cover codeword lengths 648, 1296 and 1944 across code rates 1/2, 2/3, 3/4 and 5/6.

Top module: `qc_subblock_rotator`

## Requirements
- R1: With sizeSel 0, 1 or 2 selecting Z = 27, 54 or 81, and a shift s < Z, the output satisfies dataOut[i] = dataIn[(i+s) mod Z] for every i < Z, and outErr is 0.
- R2: Input bits at positions Z and above have no effect on the result, and output bits at positions Z and above are 0.
- R3: A shift value of 127 gives an all-zero dataOut and outErr 0, for any data and for any valid size.
- R4: A shift value from Z to 126 for the chosen size gives an all-zero dataOut and outErr 1.
- R5: sizeSel 3 is unused. It gives an all-zero dataOut and outErr 1, whatever the shift value.
- R6: outValid is inValid delayed by exactly one clock cycle. dataOut and outErr show the result for the input presented in that earlier cycle.
- R7: In a cycle without inValid, dataOut and outErr keep their previous values, whatever is on dataIn, sizeSel and shiftVal.
- R8: While rst_n is low, outValid, outErr and dataOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input operation strobe |
| sizeSel | input | 2 | Size select: 0 gives Z=27, 1 gives Z=54, 2 gives Z=81, 3 is unused |
| shiftVal | input | 7 | Rotation amount; 127 selects the zero sub-matrix |
| dataIn | input | 81 | Input slice; only the low Z bits are used |
| outValid | output | 1 | Result valid, one cycle after inValid |
| dataOut | output | 81 | Rotated slice, with bits Z and above forced to zero |
| outErr | output | 1 | Shift value or size select out of range |

## Verification
The assertions assume that inValid, sizeSel, shiftVal and dataIn are known, non-X values on every clock edge after reset. Apart from that they accept any value, including unused sizes and out-of-range shifts. The bench meets this assumption by changing inputs only on the falling clock edge. It holds every input at zero during reset, and it returns inValid to zero between operations. It deliberately puts random bits above Z on dataIn and changes the idle inputs while inValid is low, so that the ignore and hold properties are actually tested.

// File: rtl/qc_rot_pkg.sv
package qc_rot_pkg;
  localparam int Z_UNIT    = 27;
  localparam int NUM_SIZES = 3;
  localparam int MAX_Z     = Z_UNIT * NUM_SIZES;
  localparam int SHIFT_W   = 7;
  localparam int SEL_W     = 2;
  localparam int ZERO_CODE = (1 << SHIFT_W) - 1;

  typedef struct packed {
    logic             load;
    logic             forceZero;
    logic             err;
    logic [SEL_W-1:0] sizeIdx;
  } rot_strobe_t;
endpackage

// File: rtl/qc_rot_ctrl.sv
module qc_rot_ctrl
  import qc_rot_pkg::*;
#(
  parameter int ZU      = Z_UNIT,
  parameter int NSIZE   = NUM_SIZES,
  parameter int SHW     = SHIFT_W,
  parameter int SW      = SEL_W,
  parameter int ZCODE   = ZERO_CODE
) (
  input  logic            inValid,
  input  logic [SW-1:0]   sizeSel,
  input  logic [SHW-1:0]  shiftVal,
  output rot_strobe_t     strobes
);
  localparam int LIM_W = SHW + 2;

  logic             sizeOk;
  logic [LIM_W-1:0] zLimit;
  logic             isZeroCode;
  logic             shiftBad;

  always_comb begin
    sizeOk = (int'(sizeSel) < NSIZE);
    zLimit = LIM_W'((int'(sizeSel) + 1) * ZU);
  end

  assign isZeroCode = (int'(shiftVal) == ZCODE);
  assign shiftBad   = !isZeroCode && (LIM_W'(shiftVal) >= zLimit);

  always_comb begin
    strobes.load      = inValid;
    strobes.err       = !sizeOk || shiftBad;
    strobes.forceZero = isZeroCode || !sizeOk || shiftBad;
    strobes.sizeIdx   = sizeSel;
  end
endmodule

// File: rtl/qc_rot_datapath.sv
module qc_rot_datapath
  import qc_rot_pkg::*;
#(
  parameter int ZU    = Z_UNIT,
  parameter int NSIZE = NUM_SIZES,
  parameter int SHW   = SHIFT_W,
  parameter int ZCODE = ZERO_CODE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rot_strobe_t          strobes,
  input  logic [SHW-1:0]       shiftVal,
  input  logic [ZU*NSIZE-1:0]  dataIn,
  output logic                 outValid,
  output logic [ZU*NSIZE-1:0]  dataOut,
  output logic                 outErr
);
  localparam int WIDTH = ZU * NSIZE;

  logic [WIDTH-1:0] rotCand  [NSIZE];
  logic [WIDTH-1:0] maskCand [NSIZE];
  logic [WIDTH-1:0] rotSel;
  logic [WIDTH-1:0] maskedIn;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int ZG = ZU * (g + 1);
    logic [2*ZG-1:0] dbl;
    logic [2*ZG-1:0] shifted;
    assign dbl         = {dataIn[ZG-1:0], dataIn[ZG-1:0]};
    assign shifted     = dbl >> shiftVal;
    assign rotCand[g]  = WIDTH'(shifted[ZG-1:0]);
    assign maskCand[g] = WIDTH'({ZG{1'b1}});
  end

  always_comb begin
    rotSel   = '0;
    maskedIn = '0;
    for (int k = 0; k < NSIZE; k++) begin
      if (int'(strobes.sizeIdx) == k) begin
        rotSel   = rotCand[k];
        maskedIn = dataIn & maskCand[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      dataOut  <= '0;
      outErr   <= 1'b0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        dataOut <= strobes.forceZero ? '0 : rotSel;
        outErr  <= strobes.err;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(strobes.load)); // R6

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load && int'(shiftVal) == ZCODE && int'(strobes.sizeIdx) < NSIZE
    |=> dataOut == '0 && !outErr); // R3

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    outErr |-> dataOut == '0); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> $stable(dataOut) && $stable(outErr)); // R7

  AST_WEIGHT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load && !strobes.forceZero
    |=> $countones(dataOut) == $past($countones(maskedIn))); // R1

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load && strobes.sizeIdx == '0 |=> dataOut[WIDTH-1:ZU] == '0); // R2
endmodule

// File: rtl/qc_subblock_rotator.sv
module qc_subblock_rotator
  import qc_rot_pkg::*;
#(
  parameter int ZU    = Z_UNIT,
  parameter int NSIZE = NUM_SIZES,
  parameter int SHW   = SHIFT_W,
  parameter int SW    = SEL_W,
  parameter int ZCODE = ZERO_CODE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [SW-1:0]       sizeSel,
  input  logic [SHW-1:0]      shiftVal,
  input  logic [ZU*NSIZE-1:0] dataIn,
  output logic                outValid,
  output logic [ZU*NSIZE-1:0] dataOut,
  output logic                outErr
);
  rot_strobe_t strobes;

  qc_rot_ctrl #(
    .ZU(ZU), .NSIZE(NSIZE), .SHW(SHW), .SW(SW), .ZCODE(ZCODE)
  ) u_ctrl (
    .inValid (inValid),
    .sizeSel (sizeSel),
    .shiftVal(shiftVal),
    .strobes (strobes)
  );

  qc_rot_datapath #(
    .ZU(ZU), .NSIZE(NSIZE), .SHW(SHW), .ZCODE(ZCODE)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .shiftVal(shiftVal),
    .dataIn  (dataIn),
    .outValid(outValid),
    .dataOut (dataOut),
    .outErr  (outErr)
  );

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && int'(sizeSel) >= NSIZE |=> outErr && dataOut == '0); // R5
endmodule

// File: tb/qc_subblock_rotator_tb.sv
module qc_subblock_rotator_tb;
  localparam int W = 81;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   sizeSel = '0;
  logic [6:0]   shiftVal = '0;
  logic [W-1:0] dataIn = '0;
  logic         outValid;
  logic [W-1:0] dataOut;
  logic         outErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  qc_subblock_rotator u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .sizeSel(sizeSel),
    .shiftVal(shiftVal), .dataIn(dataIn), .outValid(outValid),
    .dataOut(dataOut), .outErr(outErr)
  );

  function automatic logic [W-1:0] rnd81();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [W-1:0] refRot(logic [W-1:0] d, int z, int s);
    logic [W-1:0] r = '0;
    for (int i = 0; i < z; i++) r[i] = d[(i + s) % z];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] sel, logic [6:0] sh, logic [W-1:0] d);
    @(negedge clk);
    inValid = 1'b1; sizeSel = sel; shiftVal = sh; dataIn = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic test_reset();
    check("R8 valid", W'(outValid), '0);
    check("R8 err", W'(outErr), '0);
    check("R8 data", dataOut, '0);
  endtask

  task automatic test_rotate(int g);
    int z = 27 * (g + 1);
    for (int n = 0; n < 6; n++) begin
      int s = (n == 0) ? 0 : (n == 1) ? z - 1 : int'($urandom_range(z - 1, 1));
      logic [W-1:0] d = rnd81();
      apply(2'(g), 7'(s), d);
      check("R6 valid", W'(outValid), W'(1));
      check("R1 rot", dataOut, refRot(d, z, s));
      check("R1 err", W'(outErr), '0);
      if (z < W) check("R2 upper", dataOut >> z, '0);
    end
  endtask

  task automatic test_ignore_upper();
    logic [W-1:0] d = rnd81();
    logic [W-1:0] first;
    apply(2'd0, 7'd5, d);
    first = dataOut;
    apply(2'd0, 7'd5, d ^ {{(W-27){1'b1}}, 27'd0});
    check("R2 ignore", dataOut, first);
  endtask

  task automatic test_zero_code();
    for (int g = 0; g < 3; g++) begin
      apply(2'(g), 7'd127, '1);
      check("R3 data", dataOut, '0);
      check("R3 err", W'(outErr), '0);
    end
  endtask

  task automatic test_out_of_range();
    apply(2'd0, 7'd27, rnd81());
    check("R4 data z27", dataOut, '0);
    check("R4 err z27", W'(outErr), W'(1));
    apply(2'd1, 7'd126, rnd81());
    check("R4 data z54", dataOut, '0);
    check("R4 err z54", W'(outErr), W'(1));
    apply(2'd2, 7'd81, rnd81());
    check("R4 data z81", dataOut, '0);
    check("R4 err z81", W'(outErr), W'(1));
  endtask

  task automatic test_bad_size();
    apply(2'd3, 7'd0, '1);
    check("R5 data", dataOut, '0);
    check("R5 err", W'(outErr), W'(1));
    apply(2'd3, 7'd127, '1);
    check("R5 err zero code", W'(outErr), W'(1));
  endtask

  task automatic test_hold();
    logic [W-1:0] d = rnd81();
    logic [W-1:0] exp;
    apply(2'd2, 7'd40, d);
    exp = refRot(d, 81, 40);
    for (int n = 0; n < 3; n++) begin
      sizeSel = 2'd3; shiftVal = 7'(n * 30); dataIn = rnd81();
      @(negedge clk);
      check("R6 idle valid", W'(outValid), '0);
      check("R7 data", dataOut, exp);
      check("R7 err", W'(outErr), '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 3; g++) test_rotate(g);
    test_ignore_upper();
    test_zero_code();
    test_out_of_range();
    test_bad_size();
    test_hold();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule